// File: doc/BRIEF.md
# Load-Reserved Reservation Tracker

This block keeps the reservations created by load-reserved operations of a 32-bit processor and rules on every store-conditional. A load-reserved event records a word address in a small table of reservation slots. A store-conditional request is compared against the table. If its word address is held, the store-conditional passes: the block returns status 0 and raises the memory write enable. If the address is not held, the store-conditional fails: the block returns status 1 and keeps the write enable low. A trap-entry pulse, from either an environment call or an external interrupt, empties the whole table.

Several addresses can be reserved at the same time. A successful store-conditional leaves its reservation in place. When every slot is occupied, a new load-reserved replaces a slot chosen by a round-robin pointer. A load-reserved to an address that is already held reuses that slot.

Each slot is a two-state machine, SLOT_EMPTY and SLOT_HELD. A load into an empty slot moves it from SLOT_EMPTY to SLOT_HELD. A trap clear moves a held slot from SLOT_HELD back to SLOT_EMPTY. A held slot that is replaced stays in SLOT_HELD and takes the new address. The response is a three-state machine: RSP_IDLE, RSP_PASS and RSP_FAIL. From any state, a store-conditional that hits the table with no clear goes to RSP_PASS. A store-conditional that misses, or that arrives together with a clear, goes to RSP_FAIL. A cycle with no store-conditional goes to RSP_IDLE.

Top module: `resv_tracker`

## Requirements
- R1: A store-conditional to a word with no held reservation fails: sc_status = 1 and mem_wr_en = 0.
- R2: A store-conditional to a word with a held reservation passes: sc_status = 0 and mem_wr_en = 1.
- R3: Repeating a failed store-conditional to the same unreserved word fails again and writes nothing.
- R4: A passing store-conditional keeps its reservation, so a second store-conditional to that word with no new load-reserved also passes.
- R5: Distinct words reserved by back-to-back load-reserved events are all held together, up to ENTRIES of them.
- R6: trap_clear empties every slot, so a later store-conditional to any previously reserved word fails. A load-reserved in the same cycle as trap_clear is not recorded.
- R7: A store-conditional that arrives in the same cycle as trap_clear fails, even if its word was held.
- R8: Sixteen successive load-reserved / store-conditional pairs on consecutive word addresses each pass, with slots recycled once the table is full.
- R9: Address bits [1:0] are ignored; matching uses bits [31:2].
- R10: A new reservation takes the lowest-numbered empty slot. When no slot is empty, it replaces the slot named by a round-robin pointer. The pointer starts at slot 0 after reset or trap_clear and advances by one, wrapping, after each replacement.
- R11: A load-reserved to a word that is already held allocates nothing and leaves the pointer unchanged.
- R12: sc_done is high exactly in the cycle after a cycle with sc_valid high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_valid | input | 1 | Load-reserved event this cycle |
| lr_addr | input | 32 | Byte address of the load-reserved |
| sc_valid | input | 1 | Store-conditional request this cycle |
| sc_addr | input | 32 | Byte address of the store-conditional |
| trap_clear | input | 1 | Trap entry: drop all reservations |
| sc_done | output | 1 | Result valid, one cycle after sc_valid |
| sc_status | output | 32 | 0 = passed, 1 = failed; 0 when sc_done is low |
| mem_wr_en | output | 1 | Write the store-conditional data to memory |

## Verification
A slot stuck in SLOT_HELD, or one dropped too early, shows up on the next store-conditional to that word. It appears as a wrong sc_status and mem_wr_en one cycle after the request. Errors in the replacement pointer or in the refresh of a held word stay hidden until the table is full. They then show up on the store-conditional that follows the next replacement, where the wrong word survives. The tests fill the table, replace slots and check which words still pass. A trap that fails to win over a same-cycle request shows up as a write in the very next cycle.

// File: rtl/resv_pkg.sv
package resv_pkg;
    typedef enum logic {
        SLOT_EMPTY,
        SLOT_HELD
    } slot_state_t;

    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_PASS,
        RSP_FAIL
    } rsp_state_t;
endpackage

// File: rtl/resv_slot.sv
module resv_slot
    import resv_pkg::*;
#(
    parameter int TAG_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [TAG_W-1:0] load_tag,
    output logic             held,
    output logic [TAG_W-1:0] tag
);
    slot_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
            tag     <= '0;
        end else begin
            state_q <= state_d;
            if (load && !clear)
                tag <= load_tag;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (load && !clear) state_d = SLOT_HELD;
            SLOT_HELD:  if (clear)          state_d = SLOT_EMPTY;
        endcase
    end

    assign held = (state_q == SLOT_HELD);
endmodule

// File: rtl/resv_alloc.sv
module resv_alloc #(
    parameter int ENTRIES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               want,
    input  logic [ENTRIES-1:0] held,
    output logic [ENTRIES-1:0] grant
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!held[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    always_comb begin
        grant = '0;
        if (want)
            grant[any_free ? free_idx : ptr_q] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            ptr_q <= '0;
        else if (want && !any_free)
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
endmodule

// File: rtl/resv_respond.sv
module resv_respond
    import resv_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sc_valid,
    input  logic              sc_hit,
    input  logic              clear,
    output logic              sc_done,
    output logic [STAT_W-1:0] sc_status,
    output logic              mem_wr_en
);
    rsp_state_t state_q, state_d;

    always_comb begin
        if (sc_valid)
            state_d = (sc_hit && !clear) ? RSP_PASS : RSP_FAIL;
        else
            state_d = RSP_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        sc_done   = 1'b0;
        sc_status = '0;
        mem_wr_en = 1'b0;
        unique case (state_q)
            RSP_IDLE: ;
            RSP_PASS: begin
                sc_done   = 1'b1;
                mem_wr_en = 1'b1;
            end
            RSP_FAIL: begin
                sc_done   = 1'b1;
                sc_status = STAT_W'(1);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/resv_tracker.sv
module resv_tracker #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 4,
    parameter int STAT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lr_valid,
    input  logic [ADDR_W-1:0] lr_addr,
    input  logic              sc_valid,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              trap_clear,
    output logic              sc_done,
    output logic [STAT_W-1:0] sc_status,
    output logic              mem_wr_en
);
    localparam int TAG_W = ADDR_W - 2;

    logic [ENTRIES-1:0] held_vec;
    logic [ENTRIES-1:0] grant_vec;
    logic [ENTRIES-1:0] lr_match;
    logic [ENTRIES-1:0] sc_match;
    logic [TAG_W-1:0]   tag_arr [ENTRIES];
    logic               alloc_want;
    logic               unused_low;

    assign unused_low = ^{lr_addr[1:0], sc_addr[1:0]};

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        resv_slot #(.TAG_W(TAG_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (trap_clear),
            .load     (grant_vec[g]),
            .load_tag (lr_addr[ADDR_W-1:2]),
            .held     (held_vec[g]),
            .tag      (tag_arr[g])
        );
        assign lr_match[g] = held_vec[g] && (tag_arr[g] == lr_addr[ADDR_W-1:2]);
        assign sc_match[g] = held_vec[g] && (tag_arr[g] == sc_addr[ADDR_W-1:2]);
    end

    assign alloc_want = lr_valid && !trap_clear && !(|lr_match);

    resv_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (trap_clear),
        .want  (alloc_want),
        .held  (held_vec),
        .grant (grant_vec)
    );

    resv_respond #(.STAT_W(STAT_W)) u_respond (
        .clk       (clk),
        .rst_n     (rst_n),
        .sc_valid  (sc_valid),
        .sc_hit    (|sc_match),
        .clear     (trap_clear),
        .sc_done   (sc_done),
        .sc_status (sc_status),
        .mem_wr_en (mem_wr_en)
    );
endmodule

// File: rtl/resv_tracker_chk.sv
module resv_tracker_chk #(
    parameter int ENTRIES = 4,
    parameter int STAT_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lr_valid,
    input logic               sc_valid,
    input logic               trap_clear,
    input logic               sc_done,
    input logic [STAT_W-1:0]  sc_status,
    input logic               mem_wr_en,
    input logic [ENTRIES-1:0] held_vec,
    input logic [ENTRIES-1:0] grant_vec
);
    // R2
    pass_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (sc_done && sc_status == STAT_W'(0)));

    // R1
    fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_done && !mem_wr_en) |-> sc_status == STAT_W'(1));

    // R12
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid |=> sc_done);

    // R12
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_valid |=> !sc_done);

    // R7
    trap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && trap_clear) |=> !mem_wr_en);

    // R6
    wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_clear |=> held_vec == '0);

    // R10
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

    // R11
    grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_vec) |-> (lr_valid && !trap_clear));
endmodule

bind resv_tracker resv_tracker_chk #(.ENTRIES(ENTRIES), .STAT_W(STAT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lr_valid   (lr_valid),
    .sc_valid   (sc_valid),
    .trap_clear (trap_clear),
    .sc_done    (sc_done),
    .sc_status  (sc_status),
    .mem_wr_en  (mem_wr_en),
    .held_vec   (held_vec),
    .grant_vec  (grant_vec)
);

// File: tb/test_resv_tracker.sv
module test_resv_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lr_valid = 1'b0;
    logic [31:0] lr_addr = '0;
    logic        sc_valid = 1'b0;
    logic [31:0] sc_addr = '0;
    logic        trap_clear = 1'b0;
    logic        sc_done;
    logic [31:0] sc_status;
    logic        mem_wr_en;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    resv_tracker i_resv_tracker (
        .clk(clk), .rst_n(rst_n),
        .lr_valid(lr_valid), .lr_addr(lr_addr),
        .sc_valid(sc_valid), .sc_addr(sc_addr),
        .trap_clear(trap_clear),
        .sc_done(sc_done), .sc_status(sc_status), .mem_wr_en(mem_wr_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one cycle of stimulus, then released at the next falling edge
    task automatic step(input logic lv, input logic [31:0] la,
                        input logic sv, input logic [31:0] sa, input logic tc);
        @(negedge clk);
        lr_valid = lv; lr_addr = la; sc_valid = sv; sc_addr = sa; trap_clear = tc;
        @(negedge clk);
        lr_valid = 1'b0; sc_valid = 1'b0; trap_clear = 1'b0;
    endtask

    task automatic do_lr(input logic [31:0] a);
        step(1'b1, a, 1'b0, '0, 1'b0);
    endtask

    task automatic do_trap();
        step(1'b0, '0, 1'b0, '0, 1'b1);
    endtask

    task automatic do_sc(input logic [31:0] a, input logic pass, input string req);
        step(1'b0, '0, 1'b1, a, 1'b0);
        check({req, " done"},   {31'b0, sc_done},   32'd1);
        check({req, " status"}, sc_status,          pass ? 32'd0 : 32'd1);
        check({req, " wr"},     {31'b0, mem_wr_en}, {31'b0, pass});
    endtask

    task automatic t_reset();
        check("R12 reset done", {31'b0, sc_done},   32'd0);
        check("R1 reset wr",    {31'b0, mem_wr_en}, 32'd0);
        check("R1 reset status", sc_status,         32'd0);
    endtask

    task automatic t_unreserved();
        do_trap();
        do_sc(32'h1000_0000, 1'b0, "R1");
        do_sc(32'h1000_0004, 1'b0, "R1 second word");
        do_sc(32'h1000_0004, 1'b0, "R3 retry");
        @(negedge clk);
        check("R12 idle after", {31'b0, sc_done}, 32'd0);
    endtask

    task automatic t_pass_and_keep();
        do_trap();
        do_lr(32'h1000_0008);
        do_sc(32'h1000_0008, 1'b1, "R2");
        do_sc(32'h1000_0008, 1'b1, "R4 repeat");
    endtask

    task automatic t_two_held();
        do_trap();
        do_lr(32'h1000_000C);
        do_lr(32'h1000_0010);
        do_sc(32'h1000_000C, 1'b1, "R5 first");
        do_sc(32'h1000_0010, 1'b1, "R5 second");
    endtask

    task automatic t_trap();
        do_trap();
        do_lr(32'h1000_0100);
        do_trap();
        do_sc(32'h1000_0100, 1'b0, "R6 after trap");
        step(1'b1, 32'h1000_0104, 1'b0, '0, 1'b1);
        do_sc(32'h1000_0104, 1'b0, "R6 lr with trap");
    endtask

    task automatic t_trap_same_cycle();
        do_trap();
        do_lr(32'h1000_0300);
        step(1'b0, '0, 1'b1, 32'h1000_0300, 1'b1);
        check("R7 done",   {31'b0, sc_done},   32'd1);
        check("R7 status", sc_status,          32'd1);
        check("R7 wr",     {31'b0, mem_wr_en}, 32'd0);
        do_sc(32'h1000_0300, 1'b0, "R7 cleared");
    endtask

    task automatic t_sixteen();
        do_trap();
        for (int k = 0; k < 16; k++) begin
            do_lr(32'h1000_0014 + 32'(4 * k));
            do_sc(32'h1000_0014 + 32'(4 * k), 1'b1, "R8");
        end
    endtask

    task automatic t_low_bits();
        do_trap();
        do_lr(32'h1000_0208);
        do_sc(32'h1000_020B, 1'b1, "R9 same word");
        do_sc(32'h1000_020C, 1'b0, "R9 next word");
    endtask

    task automatic t_round_robin();
        do_trap();
        for (int k = 0; k < 4; k++) do_lr(32'h2000_0000 + 32'(4 * k));
        do_lr(32'h2000_0010);
        do_sc(32'h2000_0000, 1'b0, "R10 slot0 replaced");
        do_sc(32'h2000_0004, 1'b1, "R10 slot1 kept");
        do_sc(32'h2000_0010, 1'b1, "R10 new word");
        do_lr(32'h2000_0014);
        do_sc(32'h2000_0004, 1'b0, "R10 slot1 replaced");
        do_sc(32'h2000_0008, 1'b1, "R10 slot2 kept");
    endtask

    task automatic t_refresh();
        do_trap();
        for (int k = 0; k < 4; k++) do_lr(32'h3000_0000 + 32'(4 * k));
        do_lr(32'h3000_0000);
        do_lr(32'h3000_0010);
        do_sc(32'h3000_0000, 1'b0, "R11 pointer unchanged");
        do_sc(32'h3000_0004, 1'b1, "R11 no duplicate");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unreserved();
        t_pass_and_keep();
        t_two_held();
        t_trap();
        t_trap_same_cycle();
        t_sixteen();
        t_low_bits();
        t_round_robin();
        t_refresh();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule